// File: doc/BRIEF.md
# Cache Maintenance Command Controller

This block runs software-issued maintenance operations on the tag and state arrays of a small set-associative instruction cache and data cache. Software first writes the target line into an address register: a way number in the top bits and a line address below it. It then writes a command word into a control register. Each command word carries one operation bit and one or two cache-select bits. The controller checks whether that combination is legal and then performs the operation. An operation may touch one line, walk every line, fetch a line through a refill handshake, or wait for an external write buffer to drain.

When an operation finishes, or when it is rejected as illegal, the hardware clears the operation bits. The select bits are kept. Software detects completion by polling the control register or the busy pin. A rejected command causes no array change, no handshake and no error. A lookup port reads back the valid bit, lock bit and tag of any line in either cache. The refill request uses a valid/ready pair. The controller holds the request valid, with a stable way and line address, until ready is sampled high. Refill completion and drain completion are single-cycle pulses.

Top module: `cache_maint_ctrl`

## Requirements
- R1: Control register (reg_sel=0) layout: bit0 selects the instruction cache and bit1 the data cache. The operation bits are: bit2 flush-all, bit3 flush-one-line, bit4 load-and-lock, bit5 unlock-one-line, bit6 unlock-all, bit7 drain write buffer. Writing any operation bit raises busy, and busy equals "some operation bit is set". Read data above bit 7 is zero.
- R2: The address register (reg_sel=1) is 32 bits wide, reads back what was written and resets to zero. Its top WAY_W bits (bit 31 by default) hold the way. Bits [SET_W-1:0] hold the set index and the TAG_W bits above them hold the tag. With the defaults these are set [1:0] and tag [9:2].
- R3: Load-and-lock with exactly one select bit raises refill_valid. refill_way and refill_line carry the address register fields, and refill_dcache carries bit1. All of them stay stable until refill_ready is high. After the refill_done pulse, the addressed way and set of that cache hold valid=1, lock=1 and the register's tag.
- R4: Flush-one-line with exactly one select bit clears the valid and lock bits of the addressed way and set in that cache only. It completes one cycle after the write.
- R5: Flush-all clears the valid and lock bits of every line in each selected cache, including locked lines. It visits one line per clock, so busy reads high in exactly WAYS*SETS+1 consecutive cycles after the write.
- R6: Unlock-one-line (exactly one select) clears the lock bit of the addressed line. Unlock-all clears the lock bit of every line in each selected cache, and may target both caches at once. Neither changes a valid bit or a tag.
- R7: These commands are illegal: more than one operation bit set, no select bit set, or a single-line or load-and-lock command with both select bits set. Each is a silent no-op with no array change and no refill request, and it completes one cycle after the write.
- R8: Drain write buffer is legal only with bit1 set and bit0 clear. It holds drain_req high until the drain_done pulse, then completes. With bit0 set, or with bit1 clear, it is a no-op and drain_req never rises.
- R9: While busy is high, writes to either register are ignored.
- R10: On completion the operation bits read back as zero, the select bits keep their written values, and busy falls. While idle, refill_valid and drain_req are low.
- R11: The lookup port returns the valid bit, lock bit and tag of line (lk_way, lk_set) in the data cache when lk_dcache=1, and in the instruction cache otherwise. Every line reads invalid and unlocked after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = address register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the register chosen by reg_sel |
| busy | output | 1 | An operation is pending or running |
| refill_valid | output | 1 | Refill request valid |
| refill_ready | input | 1 | Refill request accepted |
| refill_way | output | WAY_W | Way of the requested line |
| refill_line | output | LINE_W | Line address (tag and set) of the request |
| refill_dcache | output | 1 | Request is for the data cache |
| refill_done | input | 1 | Refill data has been delivered (pulse) |
| drain_req | output | 1 | Request that the write buffer drain |
| drain_done | input | 1 | Write buffer is empty (pulse) |
| lk_dcache | input | 1 | Lookup cache choice |
| lk_way | input | WAY_W | Lookup way |
| lk_set | input | SET_W | Lookup set |
| lk_valid | output | 1 | Valid bit of the looked-up line |
| lk_lock | output | 1 | Lock bit of the looked-up line |
| lk_tag | output | TAG_W | Tag of the looked-up line |

## Verification
The assertions assume three things about the handshake partners. Ready only matters while a refill request is outstanding. Refill completion arrives only after the request has been accepted. Drain completion is pulsed only while a drain is requested. The bench's refill and drain responders react only to the request they observe, and they pulse completion only after the request is visible. The one exception is that writes during a busy period are issued on purpose, to show that they are dropped. Line state is checked through the lookup port, and only after busy has fallen, so no lookup result depends on a walk that is still running.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  localparam int CTRL_W    = 8;
  localparam int BIT_ISEL  = 0;
  localparam int BIT_DSEL  = 1;
  localparam int BIT_FALL  = 2;
  localparam int BIT_FLINE = 3;
  localparam int BIT_LDLK  = 4;
  localparam int BIT_ULINE = 5;
  localparam int BIT_UALL  = 6;
  localparam int BIT_DRAIN = 7;

  typedef enum logic [2:0] {
    K_NOP, K_FLUSH_ALL, K_FLUSH_LINE, K_LOAD_LOCK,
    K_UNLOCK_LINE, K_UNLOCK_ALL, K_DRAIN
  } cmd_kind_e;

  typedef enum logic [1:0] {OP_NONE, OP_INVAL, OP_UNLOCK, OP_FILL} line_op_e;
endpackage

// File: rtl/cmc_decode.sv
module cmc_decode
  import cmc_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  output cmd_kind_e         kind,
  output logic [1:0]        tgt
);
  logic [5:0] ops;
  logic [1:0] sel;
  logic       one_op;
  logic       one_sel;

  assign ops     = ctrl[CTRL_W-1:BIT_FALL];
  assign sel     = {ctrl[BIT_DSEL], ctrl[BIT_ISEL]};
  assign one_op  = $onehot(ops);
  assign one_sel = $onehot(sel);
  assign tgt     = sel;

  always_comb begin
    kind = K_NOP;
    if (!one_op || sel == 2'b00) begin
      kind = K_NOP;
    end else if (ctrl[BIT_FALL]) begin
      kind = K_FLUSH_ALL;
    end else if (ctrl[BIT_UALL]) begin
      kind = K_UNLOCK_ALL;
    end else if (ctrl[BIT_FLINE]) begin
      kind = one_sel ? K_FLUSH_LINE : K_NOP;
    end else if (ctrl[BIT_ULINE]) begin
      kind = one_sel ? K_UNLOCK_LINE : K_NOP;
    end else if (ctrl[BIT_LDLK]) begin
      kind = one_sel ? K_LOAD_LOCK : K_NOP;
    end else if (ctrl[BIT_DRAIN]) begin
      kind = (sel == 2'b10) ? K_DRAIN : K_NOP;
    end
  end
endmodule

// File: rtl/cmc_line_store.sv
module cmc_line_store
  import cmc_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int SETS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int IDX_W = WAY_W + SET_W,
  localparam int LINES = WAYS * SETS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_en,
  input  line_op_e         op,
  input  logic [WAY_W-1:0] op_way,
  input  logic [SET_W-1:0] op_set,
  input  logic [TAG_W-1:0] op_tag,
  input  logic [WAY_W-1:0] lk_way,
  input  logic [SET_W-1:0] lk_set,
  output logic             lk_valid,
  output logic             lk_lock,
  output logic [TAG_W-1:0] lk_tag
);
  logic [LINES-1:0] vld_q;
  logic [LINES-1:0] lck_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;

  assign wr_idx = {op_way, op_set};
  assign rd_idx = {lk_way, lk_set};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      lck_q <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else if (op_en) begin
      case (op)
        OP_INVAL: begin
          vld_q[wr_idx] <= 1'b0;
          lck_q[wr_idx] <= 1'b0;
        end
        OP_UNLOCK: lck_q[wr_idx] <= 1'b0;
        OP_FILL: begin
          vld_q[wr_idx] <= 1'b1;
          lck_q[wr_idx] <= 1'b1;
          tag_q[wr_idx] <= op_tag;
        end
        default: ;
      endcase
    end
  end

  assign lk_valid = vld_q[rd_idx];
  assign lk_lock  = lck_q[rd_idx];
  assign lk_tag   = tag_q[rd_idx];
endmodule

// File: rtl/cmc_seq.sv
module cmc_seq
  import cmc_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int SETS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int IDX_W = WAY_W + SET_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pending,
  input  cmd_kind_e        kind,
  input  logic [1:0]       tgt,
  input  logic [WAY_W-1:0] addr_way,
  input  logic [SET_W-1:0] addr_set,
  input  logic [TAG_W-1:0] addr_tag,
  input  logic             refill_ready,
  input  logic             refill_done,
  input  logic             drain_done,
  output logic             done,
  output line_op_e         op,
  output logic [1:0]       op_mask,
  output logic [WAY_W-1:0] op_way,
  output logic [SET_W-1:0] op_set,
  output logic [TAG_W-1:0] op_tag,
  output logic             refill_valid,
  output logic             drain_req
);
  typedef enum logic [2:0] {S_IDLE, S_WALK, S_REQ, S_WAIT, S_DRAIN} state_e;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WAYS * SETS - 1);

  state_e           state_q, state_d;
  logic [IDX_W-1:0] cnt_q;

  assign op_mask      = tgt;
  assign refill_valid = (state_q == S_REQ);
  assign drain_req    = (state_q == S_DRAIN);

  always_comb begin
    state_d = state_q;
    done    = 1'b0;
    op      = OP_NONE;
    op_way  = addr_way;
    op_set  = addr_set;
    op_tag  = addr_tag;
    case (state_q)
      S_IDLE: if (pending) begin
        case (kind)
          K_FLUSH_LINE:  begin op = OP_INVAL;  done = 1'b1; end
          K_UNLOCK_LINE: begin op = OP_UNLOCK; done = 1'b1; end
          K_FLUSH_ALL, K_UNLOCK_ALL: state_d = S_WALK;
          K_LOAD_LOCK:   state_d = S_REQ;
          K_DRAIN:       state_d = S_DRAIN;
          default:       done = 1'b1;
        endcase
      end
      S_WALK: begin
        op     = (kind == K_FLUSH_ALL) ? OP_INVAL : OP_UNLOCK;
        op_way = cnt_q[IDX_W-1:SET_W];
        op_set = cnt_q[SET_W-1:0];
        if (cnt_q == LAST_IDX) begin
          done    = 1'b1;
          state_d = S_IDLE;
        end
      end
      S_REQ: if (refill_ready) state_d = S_WAIT;
      S_WAIT: if (refill_done) begin
        op      = OP_FILL;
        done    = 1'b1;
        state_d = S_IDLE;
      end
      S_DRAIN: if (drain_done) begin
        done    = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_q == S_WALK) ? cnt_q + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/cache_maint_ctrl.sv
module cache_maint_ctrl
  import cmc_pkg::*;
#(
  parameter int WAYS   = 2,
  parameter int SETS   = 4,
  parameter int TAG_W  = 8,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SET_W  = $clog2(SETS),
  localparam int LINE_W = TAG_W + SET_W,
  localparam int AREG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [AREG_W-1:0] reg_wdata,
  output logic [AREG_W-1:0] reg_rdata,
  output logic              busy,
  output logic              refill_valid,
  input  logic              refill_ready,
  output logic [WAY_W-1:0]  refill_way,
  output logic [LINE_W-1:0] refill_line,
  output logic              refill_dcache,
  input  logic              refill_done,
  output logic              drain_req,
  input  logic              drain_done,
  input  logic              lk_dcache,
  input  logic [WAY_W-1:0]  lk_way,
  input  logic [SET_W-1:0]  lk_set,
  output logic              lk_valid,
  output logic              lk_lock,
  output logic [TAG_W-1:0]  lk_tag
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [AREG_W-1:0] addr_q;
  cmd_kind_e         kind;
  logic [1:0]        tgt;
  logic              done;
  line_op_e          op;
  logic [1:0]        op_mask;
  logic [WAY_W-1:0]  op_way;
  logic [SET_W-1:0]  op_set;
  logic [TAG_W-1:0]  op_tag;
  logic [WAY_W-1:0]  addr_way;
  logic [SET_W-1:0]  addr_set;
  logic [TAG_W-1:0]  addr_tag;
  logic [1:0]        c_valid;
  logic [1:0]        c_lock;
  logic [TAG_W-1:0]  c_tag [2];

  assign busy     = |ctrl_q[CTRL_W-1:BIT_FALL];
  assign addr_way = addr_q[AREG_W-1 -: WAY_W];
  assign addr_set = addr_q[SET_W-1:0];
  assign addr_tag = addr_q[LINE_W-1:SET_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      addr_q <= '0;
    end else begin
      if (reg_wr && !busy) begin
        if (reg_sel) addr_q <= reg_wdata;
        else         ctrl_q <= reg_wdata[CTRL_W-1:0];
      end else if (done) begin
        ctrl_q[CTRL_W-1:BIT_FALL] <= '0;
      end
    end
  end

  assign reg_rdata = reg_sel ? addr_q : {{(AREG_W-CTRL_W){1'b0}}, ctrl_q};

  cmc_decode u_dec (.ctrl(ctrl_q), .kind(kind), .tgt(tgt));

  cmc_seq #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .pending(busy), .kind(kind), .tgt(tgt),
    .addr_way(addr_way), .addr_set(addr_set), .addr_tag(addr_tag),
    .refill_ready(refill_ready), .refill_done(refill_done), .drain_done(drain_done),
    .done(done), .op(op), .op_mask(op_mask), .op_way(op_way), .op_set(op_set),
    .op_tag(op_tag), .refill_valid(refill_valid), .drain_req(drain_req)
  );

  for (genvar c = 0; c < 2; c++) begin : g_cache
    cmc_line_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_store (
      .clk(clk), .rst_n(rst_n), .op_en(op_mask[c]), .op(op),
      .op_way(op_way), .op_set(op_set), .op_tag(op_tag),
      .lk_way(lk_way), .lk_set(lk_set),
      .lk_valid(c_valid[c]), .lk_lock(c_lock[c]), .lk_tag(c_tag[c])
    );
  end

  assign refill_way    = addr_way;
  assign refill_line   = addr_q[LINE_W-1:0];
  assign refill_dcache = ctrl_q[BIT_DSEL];

  assign lk_valid = c_valid[lk_dcache];
  assign lk_lock  = c_lock[lk_dcache];
  assign lk_tag   = c_tag[lk_dcache];
endmodule

// File: rtl/cmc_checker.sv
module cmc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic [7:0]  ctrl_q,
  input logic [31:0] addr_q,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic        refill_valid,
  input logic        refill_ready,
  input logic        drain_req
);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid && !refill_ready |=> refill_valid && $stable(addr_q) && $stable(ctrl_q));

  assert_req_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid |-> $onehot(ctrl_q[1:0]) && ctrl_q[4] && $countones(ctrl_q[7:2]) == 1);

  assert_drain_dsel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req |-> ctrl_q[1:0] == 2'b10 && ctrl_q[7:2] == 6'b100000);

  assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr && reg_sel |=> $stable(addr_q));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !refill_valid && !drain_req);

  assert_sel_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ctrl_q[1:0] == $past(ctrl_q[1:0]));
endmodule

bind cache_maint_ctrl cmc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ctrl_q(ctrl_q), .addr_q(addr_q),
  .reg_wr(reg_wr), .reg_sel(reg_sel), .refill_valid(refill_valid),
  .refill_ready(refill_ready), .drain_req(drain_req)
);

// File: tb/cache_maint_ctrl_tb.sv
module cache_maint_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy;
  logic        refill_valid;
  logic        refill_ready = 1'b0;
  logic [0:0]  refill_way;
  logic [9:0]  refill_line;
  logic        refill_dcache;
  logic        refill_done = 1'b0;
  logic        drain_req;
  logic        drain_done = 1'b0;
  logic        lk_dcache = 1'b0;
  logic [0:0]  lk_way = '0;
  logic [1:0]  lk_set = '0;
  logic        lk_valid;
  logic        lk_lock;
  logic [7:0]  lk_tag;

  int checks = 0;
  int failures = 0;
  int refill_seen = 0;
  int drain_hi = 0;
  logic [0:0] cap_way;
  logic [9:0] cap_line;
  logic       cap_dc;

  typedef struct {
    string      r;
    logic       v;
    logic       l;
    logic [7:0] tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  cache_maint_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .refill_valid(refill_valid), .refill_ready(refill_ready),
    .refill_way(refill_way), .refill_line(refill_line),
    .refill_dcache(refill_dcache), .refill_done(refill_done),
    .drain_req(drain_req), .drain_done(drain_done),
    .lk_dcache(lk_dcache), .lk_way(lk_way), .lk_set(lk_set),
    .lk_valid(lk_valid), .lk_lock(lk_lock), .lk_tag(lk_tag)
  );

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [31:0] mk(logic way, logic [7:0] tag, logic [1:0] set);
    return {way, 21'd0, tag, set};
  endfunction

  task automatic wr(logic sel, logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic sel, output logic [31:0] v);
    reg_sel = sel;
    #1;
    v = reg_rdata;
  endtask

  // Issue a command and count the cycles busy reads high after the write.
  task automatic run_cmd(logic [7:0] c, output int n);
    wr(1'b0, {24'd0, c});
    n = 0;
    while (busy && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Scoreboard driver: point the lookup port at a line and queue its expected state.
  task automatic expect_line(string r, logic dc, logic way, logic [1:0] set,
                             logic v, logic l, logic [7:0] tag);
    exp_t it;
    @(negedge clk);
    lk_dcache = dc; lk_way = way; lk_set = set;
    it.r = r; it.v = v; it.l = l; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  // Scoreboard monitor
  initial forever begin
    @(posedge clk);
    #2;
    if (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      check({it.r, " valid"}, {31'd0, lk_valid}, {31'd0, it.v});
      check({it.r, " lock"}, {31'd0, lk_lock}, {31'd0, it.l});
      if (it.v) check({it.r, " tag"}, {24'd0, lk_tag}, {24'd0, it.tag});
    end
  end

  // Refill responder
  initial forever begin
    @(negedge clk);
    if (refill_valid) begin
      cap_way = refill_way; cap_line = refill_line; cap_dc = refill_dcache;
      refill_seen++;
      repeat (2) @(negedge clk);
      check("R3 request held until ready", {20'd0, refill_valid, refill_way, refill_line},
            {20'd0, 1'b1, cap_way, cap_line});
      refill_ready = 1'b1;
      @(negedge clk);
      refill_ready = 1'b0;
      repeat (2) @(negedge clk);
      refill_done = 1'b1;
      @(negedge clk);
      refill_done = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (drain_req) drain_hi++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    int n;
    int seen0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    rd(1'b0, v); check("R1 ctrl reset", v, 32'h0);
    rd(1'b1, v); check("R2 addr reset", v, 32'h0);
    check("R1 busy reset", {31'd0, busy}, 32'h0);
    expect_line("R11 reset line", 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 8'h00);

    // Address register layout and readback
    wr(1'b1, mk(1'b1, 8'h5A, 2'd2));
    rd(1'b1, v); check("R2 addr readback", v, 32'h8000_016A);

    // Load-and-lock into the data cache
    wr(1'b0, 32'h12);
    check("R1 busy after command", {31'd0, busy}, 32'h1);
    while (busy) @(negedge clk);
    check("R3 refill way", {31'd0, cap_way}, 32'h1);
    check("R3 refill line", {22'd0, cap_line}, 32'h16A);
    check("R3 refill dcache", {31'd0, cap_dc}, 32'h1);
    rd(1'b0, v); check("R10 command bits cleared, select kept", v, 32'h02);
    expect_line("R3 D w1 s2 locked", 1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 8'h5A);
    expect_line("R11 I w1 s2 untouched", 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 8'h00);

    // More lines
    wr(1'b1, mk(1'b0, 8'h33, 2'd1)); run_cmd(8'h11, n);
    wr(1'b1, mk(1'b0, 8'h44, 2'd3)); run_cmd(8'h12, n);
    wr(1'b1, mk(1'b1, 8'h11, 2'd0)); run_cmd(8'h12, n);
    expect_line("R3 I w0 s1 locked", 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 8'h33);
    check("R3 three more refills", refill_seen, 32'd4);

    // Illegal combinations
    seen0 = refill_seen;
    wr(1'b1, mk(1'b1, 8'h5A, 2'd2));
    run_cmd(8'h0B, n);
    check("R7 flush-line both caches completes at once", n, 32'd1);
    expect_line("R7 flush-line both caches no-op", 1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 8'h5A);
    run_cmd(8'h0E, n);
    check("R7 two command bits completes at once", n, 32'd1);
    expect_line("R7 two command bits no-op", 1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 8'h5A);
    run_cmd(8'h13, n);
    run_cmd(8'h10, n);
    check("R7 load-lock no select completes at once", n, 32'd1);
    check("R7 no refill for illegal load-lock", refill_seen, seen0);
    run_cmd(8'h23, n);
    expect_line("R7 unlock-line both caches no-op", 1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 8'h5A);
    run_cmd(8'h83, n);
    check("R8 drain with I select completes at once", n, 32'd1);
    run_cmd(8'h81, n);
    check("R8 drain without D select no request", drain_hi, 32'd0);

    // Unlock one line
    run_cmd(8'h22, n);
    check("R6 unlock-line latency", n, 32'd1);
    expect_line("R6 unlock-line keeps valid", 1'b1, 1'b1, 2'd2, 1'b1, 1'b0, 8'h5A);

    // Flush one line
    wr(1'b1, mk(1'b0, 8'h44, 2'd3));
    run_cmd(8'h0A, n);
    check("R4 flush-line latency", n, 32'd1);
    expect_line("R4 D w0 s3 flushed", 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 8'h00);
    expect_line("R4 D w1 s0 kept", 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 8'h11);

    // Drain and writes ignored while busy
    wr(1'b0, 32'h82);
    @(negedge clk);
    check("R8 drain_req high", {31'd0, drain_req}, 32'h1);
    wr(1'b1, 32'h1234_5678);
    wr(1'b0, 32'h06);
    rd(1'b1, v); check("R9 addr write ignored when busy", v, mk(1'b0, 8'h44, 2'd3));
    rd(1'b0, v); check("R9 ctrl write ignored when busy", v, 32'h82);
    check("R8 drain_req held", {31'd0, drain_req}, 32'h1);
    drain_done = 1'b1;
    @(negedge clk);
    drain_done = 1'b0;
    rd(1'b0, v); check("R8 drain completes after done", v, 32'h02);
    check("R10 busy low after drain", {31'd0, busy}, 32'h0);

    // Unlock all in both caches
    run_cmd(8'h43, n);
    check("R6 unlock-all latency", n, 32'd9);
    expect_line("R6 unlock-all I line", 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 8'h33);
    expect_line("R6 unlock-all D line", 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 8'h11);

    // Re-lock then flush-all of the data cache
    wr(1'b1, mk(1'b1, 8'h11, 2'd0)); run_cmd(8'h12, n);
    expect_line("R3 relock D w1 s0", 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 8'h11);
    run_cmd(8'h06, n);
    check("R5 flush-all busy cycles", n, 32'd9);
    expect_line("R5 locked D line flushed", 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 8'h00);
    expect_line("R5 D w1 s2 flushed", 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 8'h00);
    expect_line("R5 I line untouched", 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 8'h33);
    run_cmd(8'h07, n);
    expect_line("R5 both caches flushed", 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 8'h00);
    rd(1'b0, v); check("R10 select bits kept", v, 32'h03);

    summary();
  end
endmodule